// File: doc/BRIEF.md
# Oversampling Serial Receiver with Address Filter

This block turns an asynchronous serial line into characters. It works from the core clock and uses a one-cycle enable that pulses at sixteen times the bit rate. The line first passes through a two-stage synchroniser. A falling edge restarts the sample divider, and the start bit is checked again half a bit later. After that, each bit is taken at the centre of its cell. Characters are 5 to 8 data bits, least significant bit first. A parity bit is optional and a stop bit follows. Each finished character is offered to a downstream store as a single write strobe. The strobe carries the data byte and three flags: parity/address, framing and break.

The block recognises a break line and gives it special handling. It also restarts cleanly on a framing error when the line stays low. When the store reports full, the block holds one character and flags an overrun if another start bit arrives before there is room. In the address mode, the parity position carries an address/data flag. While the receiver is disabled, characters with a clear flag are filtered out. A watchdog pulses when 64 bit times pass with no write and no read of the store.

Top module: `ovs_uart_rx`

## Requirements
- R1: A falling edge on the synchronised line resets the 16-step divider. If the line is still low at divider count 7, a start bit is accepted. If it is high, no character is produced and the receiver waits for the next falling edge.
- R2: Each data, parity and stop bit is taken when the divider passes count 7 of its sixteen-tick cell. Data arrives least significant bit first. `cfg_bits` sets the length: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8 data bits.
- R3: For characters shorter than 8 bits, the unused upper bits of `wr_data` are zero.
- R4: `cfg_par` selects the parity mode: 0 none, 1 even, 2 odd, 3 space (bit must be 0), 4 mark (bit must be 1), 5 address, and 6 or 7 none. `wr_perr` is set when the parity bit breaks the rule. `wr_ferr` is set when the stop bit is low.
- R5: A character whose data, parity and stop bits are all low is a break. Exactly one character is written with data 0, `wr_brk`=1, `wr_ferr`=1 and `wr_perr`=0 (the flag value in address mode). `brk_change` pulses for one cycle.
- R6: After a break, the synchronised line must be high on two consecutive clock edges. Only then does `brk_change` pulse again and edge search resume. A one-cycle high does not end the break.
- R7: After a framing error that is not a break, the line is checked half a bit after the stop sample. If it is low, that point counts as a new start edge.
- R8: In address mode (`cfg_par`=5), `wr_perr` carries the address flag. With `rx_enable` low, only characters whose flag is 1 are written. With it high, all characters are written.
- R9: In every other parity mode, no character is written while `rx_enable` is low.
- R10: If `fifo_full` is high when a character completes, the character is held and written in the cycle after `fifo_full` is first seen low. `wr_en` never rises in the cycle after `fifo_full` was high.
- R11: If a start bit is accepted while a character is held, the held character is discarded and `overrun` pulses for one cycle.
- R12: With `wdog_en` high, `wdog_expire` pulses once when 64 bit times (1024 ticks) pass without a write or a `fifo_read`. With `wdog_en` low, it never pulses.
- R13: After reset, `wr_en`, `overrun`, `brk_change` and `wdog_expire` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Enable pulse at sixteen times the bit rate |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rx_enable | input | 1 | Receiver fully enabled |
| cfg_bits | input | 2 | Data length code (5 to 8 bits) |
| cfg_par | input | 3 | Parity / address mode |
| wdog_en | input | 1 | Watchdog enable |
| fifo_full | input | 1 | Downstream store cannot accept a write |
| fifo_read | input | 1 | Downstream store was read (restarts watchdog) |
| wr_en | output | 1 | Write strobe for one character |
| wr_data | output | 8 | Received data byte |
| wr_perr | output | 1 | Parity error, or address flag in address mode |
| wr_ferr | output | 1 | Framing error |
| wr_brk | output | 1 | Character is a break |
| overrun | output | 1 | One-cycle pulse: held character lost |
| brk_change | output | 1 | One-cycle pulse when a break starts or ends |
| wdog_expire | output | 1 | One-cycle pulse when the watchdog runs out |

## Verification
Two things can happen in the same stretch of time: the store regaining space, and the start bit of the next character being accepted. Both the release of the held character and the overrun decision depend on which comes first. The bench holds the store full across two back-to-back characters, so acceptance of the second start bit meets a held first character. The expected result is a single overrun pulse, the first character lost and the second delivered on release. A separate case releases the store before the next start bit, and the expected result is no overrun.

// File: rtl/orx_pkg.sv
package orx_pkg;

    typedef enum logic [2:0] {
        PM_NONE  = 3'd0,
        PM_EVEN  = 3'd1,
        PM_ODD   = 3'd2,
        PM_SPACE = 3'd3,
        PM_MARK  = 3'd4,
        PM_ADDR  = 3'd5
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_REARM,
        ST_BRKW
    } rx_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       perr;
        logic       ferr;
        logic       brk;
    } rx_char_t;

endpackage

// File: rtl/orx_sync.sv
module orx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_q, sh_d;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/orx_frame.sv
module orx_frame
    import orx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx,
    input  logic       rx_enable,
    input  logic [1:0] cfg_bits,
    input  logic [2:0] cfg_par,
    output logic       chr_v,
    output rx_char_t   chr,
    output logic       start_ok,
    output logic       brk_chg
);
    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] MID_C = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] TOP_C = CW'(OVS - 1);

    typedef struct packed {
        rx_state_e     st;
        logic [CW-1:0] cnt;
        logic [2:0]    bidx;
        logic [7:0]    data;
        logic          par;
        logic          line;
        logic          hi;
        logic          chr_v;
        rx_char_t      chr;
        logic          start_ok;
        logic          brk_chg;
    } fr_t;

    fr_t q, n;

    par_mode_e mode;
    logic      fall, mid, par_on, perr_c, keep, all_low;
    logic [2:0] nlast;

    always_comb begin
        mode    = par_mode_e'(cfg_par);
        nlast   = 3'd4 + {1'b0, cfg_bits};
        par_on  = (cfg_par >= 3'd1) && (cfg_par <= 3'd5);
        fall    = q.line & ~rx;
        mid     = tick & (q.cnt == MID_C);
        all_low = (q.data == 8'h00) && (!par_on || !q.par);
        keep    = rx_enable | ((mode == PM_ADDR) & q.par);
        case (mode)
            PM_EVEN:  perr_c = ^{q.data, q.par};
            PM_ODD:   perr_c = ~^{q.data, q.par};
            PM_SPACE: perr_c = q.par;
            PM_MARK:  perr_c = ~q.par;
            PM_ADDR:  perr_c = q.par;
            default:  perr_c = 1'b0;
        endcase

        n          = q;
        n.line     = rx;
        n.chr_v    = 1'b0;
        n.start_ok = 1'b0;
        n.brk_chg  = 1'b0;
        if (tick && q.st != ST_IDLE && q.st != ST_BRKW) n.cnt = q.cnt + 1'b1;

        case (q.st)
            ST_IDLE: begin
                if (fall) begin
                    n.st  = ST_START;
                    n.cnt = '0;
                end
            end
            ST_START: begin
                if (mid) begin
                    if (!rx) begin
                        n.st       = ST_DATA;
                        n.bidx     = 3'd0;
                        n.data     = 8'h00;
                        n.par      = 1'b0;
                        n.start_ok = 1'b1;
                    end else begin
                        n.st = ST_IDLE;
                    end
                end
            end
            ST_DATA: begin
                if (mid) begin
                    n.data[q.bidx] = rx;
                    if (q.bidx == nlast) n.st = par_on ? ST_PAR : ST_STOP;
                    else                 n.bidx = q.bidx + 3'd1;
                end
            end
            ST_PAR: begin
                if (mid) begin
                    n.par = rx;
                    n.st  = ST_STOP;
                end
            end
            ST_STOP: begin
                if (mid) begin
                    n.chr.data = q.data;
                    n.chr.perr = perr_c;
                    n.chr.ferr = ~rx;
                    n.chr.brk  = 1'b0;
                    n.chr_v    = keep;
                    if (rx) begin
                        n.st = ST_IDLE;
                    end else if (all_low) begin
                        n.chr.perr = (mode == PM_ADDR) ? q.par : 1'b0;
                        n.chr.brk  = 1'b1;
                        n.brk_chg  = 1'b1;
                        n.hi       = 1'b0;
                        n.st       = ST_BRKW;
                    end else begin
                        n.st = ST_REARM;
                    end
                end
            end
            ST_REARM: begin
                if (tick && q.cnt == TOP_C) begin
                    if (!rx) begin
                        n.st  = ST_START;
                        n.cnt = '0;
                    end else begin
                        n.st = ST_IDLE;
                    end
                end
            end
            ST_BRKW: begin
                n.hi = rx;
                if (rx && q.hi) begin
                    n.st      = ST_IDLE;
                    n.brk_chg = 1'b1;
                end
            end
            default: n.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.line <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign chr_v    = q.chr_v;
    assign chr      = q.chr;
    assign start_ok = q.start_ok;
    assign brk_chg  = q.brk_chg;
endmodule

// File: rtl/orx_hold.sv
module orx_hold
    import orx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     chr_v,
    input  rx_char_t chr,
    input  logic     start_ok,
    input  logic     fifo_full,
    output logic     wr_en,
    output rx_char_t wr_chr,
    output logic     ovr
);
    typedef struct packed {
        logic     held;
        logic     wr;
        logic     ovr;
        rx_char_t chr;
    } hd_t;

    hd_t q, n;

    always_comb begin
        n     = q;
        n.wr  = 1'b0;
        n.ovr = 1'b0;
        if (start_ok && q.held) begin
            n.held = 1'b0;
            n.ovr  = 1'b1;
        end else if (q.held && !fifo_full) begin
            n.held = 1'b0;
            n.wr   = 1'b1;
        end
        if (chr_v) begin
            n.chr = chr;
            if (!fifo_full) n.wr   = 1'b1;
            else            n.held = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign wr_en  = q.wr;
    assign wr_chr = q.chr;
    assign ovr    = q.ovr;
endmodule

// File: rtl/orx_wdog.sv
module orx_wdog #(
    parameter int OVS   = 16,
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic en,
    input  logic restart,
    output logic expire
);
    localparam int CW = $clog2(OVS);
    localparam int LW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] PTOP_C = CW'(OVS - 1);
    localparam logic [LW-1:0] LIM_C  = LW'(LIMIT);
    localparam logic [LW-1:0] LIM1_C = LW'(LIMIT - 1);

    typedef struct packed {
        logic [CW-1:0] pre;
        logic [LW-1:0] bits;
        logic          exp;
    } wd_t;

    wd_t q, n;

    always_comb begin
        n     = q;
        n.exp = 1'b0;
        if (!en || restart) begin
            n.pre  = '0;
            n.bits = '0;
        end else if (tick && q.bits != LIM_C) begin
            n.pre = q.pre + 1'b1;
            if (q.pre == PTOP_C) begin
                n.bits = q.bits + 1'b1;
                if (q.bits == LIM1_C) n.exp = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign expire = q.exp;
endmodule

// File: rtl/ovs_uart_rx.sv
module ovs_uart_rx
    import orx_pkg::*;
#(
    parameter int OVS        = 16,
    parameter int SYNC_STG   = 2,
    parameter int WDOG_LIMIT = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       rx_line,
    input  logic       rx_enable,
    input  logic [1:0] cfg_bits,
    input  logic [2:0] cfg_par,
    input  logic       wdog_en,
    input  logic       fifo_full,
    input  logic       fifo_read,
    output logic       wr_en,
    output logic [7:0] wr_data,
    output logic       wr_perr,
    output logic       wr_ferr,
    output logic       wr_brk,
    output logic       overrun,
    output logic       brk_change,
    output logic       wdog_expire
);
    logic     rx_s, chr_v, start_ok;
    rx_char_t chr, wr_chr;

    orx_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(rx_s)
    );

    orx_frame #(.OVS(OVS)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .rx(rx_s),
        .rx_enable(rx_enable), .cfg_bits(cfg_bits), .cfg_par(cfg_par),
        .chr_v(chr_v), .chr(chr), .start_ok(start_ok), .brk_chg(brk_change)
    );

    orx_hold u_hold (
        .clk(clk), .rst_n(rst_n), .chr_v(chr_v), .chr(chr),
        .start_ok(start_ok), .fifo_full(fifo_full),
        .wr_en(wr_en), .wr_chr(wr_chr), .ovr(overrun)
    );

    orx_wdog #(.OVS(OVS), .LIMIT(WDOG_LIMIT)) u_wdog (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .en(wdog_en),
        .restart(wr_en | fifo_read), .expire(wdog_expire)
    );

    assign wr_data = wr_chr.data;
    assign wr_perr = wr_chr.perr;
    assign wr_ferr = wr_chr.ferr;
    assign wr_brk  = wr_chr.brk;
endmodule

// File: rtl/ovs_uart_rx_chk.sv
module ovs_uart_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_enable,
    input logic [1:0] cfg_bits,
    input logic [2:0] cfg_par,
    input logic       wdog_en,
    input logic       fifo_full,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       wr_perr,
    input logic       wr_ferr,
    input logic       wr_brk,
    input logic       overrun,
    input logic       wdog_expire
);
    AST_SHORT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cfg_bits == 2'b00) |-> (wr_data[7:5] == 3'b000)); // R3

    AST_BRK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_brk) |-> (wr_data == 8'h00 && wr_ferr)); // R5

    AST_ADDR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cfg_par == 3'd5 && !rx_enable) |-> wr_perr); // R8

    AST_HOLD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_en) |-> !$past(fifo_full)); // R10

    AST_OVR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> !overrun); // R11

    AST_OVR_NOWR: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> !wr_en); // R11

    AST_WDOG_EN: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_expire |-> $past(wdog_en)); // R12
endmodule

bind ovs_uart_rx ovs_uart_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .cfg_bits(cfg_bits),
    .cfg_par(cfg_par), .wdog_en(wdog_en), .fifo_full(fifo_full),
    .wr_en(wr_en), .wr_data(wr_data), .wr_perr(wr_perr), .wr_ferr(wr_ferr),
    .wr_brk(wr_brk), .overrun(overrun), .wdog_expire(wdog_expire)
);

// File: tb/tb_ovs_uart_rx.sv
`timescale 1ns/1ps
module tb_ovs_uart_rx;
    localparam int TDIV    = 4;
    localparam int BIT_CLK = 16 * TDIV;

    logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0, rx_line = 1'b1;
    logic rx_enable = 1'b1, wdog_en = 1'b0, fifo_full = 1'b0, fifo_read = 1'b0;
    logic [1:0] cfg_bits = 2'd3;
    logic [2:0] cfg_par = 3'd0;
    logic wr_en, wr_perr, wr_ferr, wr_brk, overrun, brk_change, wdog_expire;
    logic [7:0] wr_data;

    int total = 0, bad = 0, cap_n = 0, ovr_cnt = 0, brk_cnt = 0, wd_cnt = 0;
    logic [10:0] cap [0:255];
    bit done = 0;

    always #2.5 clk = ~clk;

    ovs_uart_rx dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_line(rx_line),
        .rx_enable(rx_enable), .cfg_bits(cfg_bits), .cfg_par(cfg_par),
        .wdog_en(wdog_en), .fifo_full(fifo_full), .fifo_read(fifo_read),
        .wr_en(wr_en), .wr_data(wr_data), .wr_perr(wr_perr), .wr_ferr(wr_ferr),
        .wr_brk(wr_brk), .overrun(overrun), .brk_change(brk_change),
        .wdog_expire(wdog_expire)
    );

    initial begin
        forever begin
            repeat (TDIV - 1) @(negedge clk);
            tick16 = 1'b1;
            @(negedge clk);
            tick16 = 1'b0;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_en) begin
                cap[cap_n[7:0]] = {wr_data, wr_perr, wr_ferr, wr_brk};
                cap_n++;
            end
            if (overrun)     ovr_cnt++;
            if (brk_change)  brk_cnt++;
            if (wdog_expire) wd_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mask_of(input int nb);
        return 8'hFF >> (8 - nb);
    endfunction

    function automatic bit has_par(input int pm);
        return pm >= 1 && pm <= 5;
    endfunction

    function automatic logic good_par(input logic [7:0] d, input int nb, input int pm, input logic flag);
        logic [7:0] m = d & mask_of(nb);
        case (pm)
            1: return ^m;
            2: return ~^m;
            4: return 1'b1;
            5: return flag;
            default: return 1'b0;
        endcase
    endfunction

    task automatic drive(input logic v, input int nbits);
        rx_line = v;
        repeat (nbits * BIT_CLK) @(negedge clk);
    endtask

    task automatic set_cfg(input int nb, input int pm, input logic en);
        cfg_bits  = 2'(nb - 5);
        cfg_par   = 3'(pm);
        rx_enable = en;
    endtask

    task automatic send(input logic [7:0] d, input int nb, input int pm, input logic pv, input logic sv);
        drive(1'b0, 1);
        for (int i = 0; i < nb; i++) drive(d[i], 1);
        if (has_par(pm)) drive(pv, 1);
        drive(sv, 1);
    endtask

    task automatic chk_char(input int idx, input logic [7:0] d, input logic pe, input logic fe,
                            input logic bk, input string req);
        logic [10:0] e = {d, pe, fe, bk};
        chk(cap[idx[7:0]] === e, req, int'(cap[idx[7:0]]), int'(e));
    endtask

    initial begin
        int base;
        void'($urandom(32'h5eed_0c1a));
        repeat (5) @(negedge clk);
        // R13: reset state
        chk(wr_en === 1'b0 && overrun === 1'b0 && brk_change === 1'b0 && wdog_expire === 1'b0,
            "R13 outputs in reset", {wr_en, overrun, brk_change, wdog_expire}, 0);
        rst_n = 1'b1;
        drive(1'b1, 2);
        chk(cap_n == 0 && ovr_cnt == 0 && brk_cnt == 0, "R13 idle after reset", cap_n, 0);

        // R1: short low glitch is not a start bit
        set_cfg(8, 0, 1'b1);
        rx_line = 1'b0; repeat (5 * TDIV) @(negedge clk);
        drive(1'b1, 2);
        chk(cap_n == 0, "R1 glitch rejected", cap_n, 0);
        send(8'hA5, 8, 0, 1'b0, 1'b1); drive(1'b1, 2);
        chk(cap_n == 1, "R1 valid start", cap_n, 1);
        chk_char(0, 8'hA5, 1'b0, 1'b0, 1'b0, "R2 8N1 data lsb first");

        // R3: 5-bit char with upper bits on the line ignored
        set_cfg(5, 0, 1'b1);
        base = cap_n;
        send(8'hFF, 5, 0, 1'b0, 1'b1); drive(1'b1, 2);
        chk(cap_n == base + 1, "R3 count", cap_n, base + 1);
        chk_char(base, 8'h1F, 1'b0, 1'b0, 1'b0, "R3 upper zero");

        // random mix, R2 R4 R9
        for (int it = 0; it < 30; it++) begin
            int nb = 5 + int'($urandom % 4);
            int pm = int'($urandom % 6);
            logic [7:0] d = 8'($urandom);
            bit badp = ($urandom % 4) == 0;
            bit en = ($urandom % 5) != 0;
            logic pv;
            if (pm == 5) pm = 6;
            pv = good_par(d, nb, pm, 1'b0) ^ (badp && has_par(pm));
            set_cfg(nb, pm, en);
            base = cap_n;
            send(d, nb, pm, pv, 1'b1); drive(1'b1, 2);
            if (en) begin
                chk(cap_n == base + 1, "R2 random count", cap_n, base + 1);
                chk_char(base, d & mask_of(nb), badp && has_par(pm), 1'b0, 1'b0, "R4 random char");
            end else begin
                chk(cap_n == base, "R9 disabled drop", cap_n, base);
            end
        end
        chk(wd_cnt == 0, "R12 no expiry when disabled", wd_cnt, 0);

        // R4: stop low with nonzero data, line back high
        set_cfg(8, 1, 1'b1);
        base = cap_n;
        send(8'h81, 8, 1, 1'b0, 1'b0); drive(1'b1, 3);
        chk(cap_n == base + 1, "R4 framing count", cap_n, base + 1);
        chk_char(base, 8'h81, 1'b0, 1'b1, 1'b0, "R4 framing flag");

        // R5 / R6: break
        set_cfg(8, 0, 1'b1);
        base = cap_n;
        drive(1'b0, 14);
        chk(cap_n == base + 1, "R5 single break char", cap_n, base + 1);
        chk_char(base, 8'h00, 1'b0, 1'b1, 1'b1, "R5 break char");
        chk(brk_cnt == 1, "R5 break change start", brk_cnt, 1);
        rx_line = 1'b1; @(negedge clk); rx_line = 1'b0;
        repeat (20) @(negedge clk);
        chk(brk_cnt == 1, "R6 one-cycle high ignored", brk_cnt, 1);
        drive(1'b1, 1);
        chk(brk_cnt == 2, "R6 break end", brk_cnt, 2);
        chk(cap_n == base + 1, "R5 no extra break chars", cap_n, base + 1);
        send(8'h3C, 8, 0, 1'b0, 1'b1); drive(1'b1, 2);
        chk_char(base + 1, 8'h3C, 1'b0, 1'b0, 1'b0, "R6 resume after break");

        // R7: framing error re-arm into a back-to-back low start
        base = cap_n;
        send(8'h5A, 8, 0, 1'b0, 1'b0);
        drive(1'b0, 1);
        for (int i = 0; i < 8; i++) drive(i[0] ? 1'b1 : 1'b0, 1);
        drive(1'b1, 3);
        chk(cap_n == base + 2, "R7 count", cap_n, base + 2);
        chk_char(base, 8'h5A, 1'b0, 1'b1, 1'b0, "R7 first char");
        chk_char(base + 1, 8'hAA, 1'b0, 1'b0, 1'b0, "R7 re-armed char");

        // R8: address mode filter
        set_cfg(8, 5, 1'b0);
        base = cap_n;
        send(8'h21, 8, 5, 1'b1, 1'b1); drive(1'b1, 2);
        send(8'h33, 8, 5, 1'b0, 1'b1); drive(1'b1, 2);
        chk(cap_n == base + 1, "R8 filter disabled", cap_n, base + 1);
        chk_char(base, 8'h21, 1'b1, 1'b0, 1'b0, "R8 address char");
        rx_enable = 1'b1;
        send(8'h44, 8, 5, 1'b0, 1'b1); drive(1'b1, 2);
        send(8'h55, 8, 5, 1'b1, 1'b1); drive(1'b1, 2);
        chk(cap_n == base + 3, "R8 enabled count", cap_n, base + 3);
        chk_char(base + 1, 8'h44, 1'b0, 1'b0, 1'b0, "R8 data flag");
        chk_char(base + 2, 8'h55, 1'b1, 1'b0, 1'b0, "R8 addr flag enabled");

        // R10 / R11: hold and overrun
        set_cfg(8, 0, 1'b1);
        base = cap_n;
        fifo_full = 1'b1;
        send(8'h11, 8, 0, 1'b0, 1'b1); drive(1'b1, 2);
        chk(cap_n == base, "R10 held while full", cap_n, base);
        fifo_full = 1'b0; repeat (4) @(negedge clk);
        chk(cap_n == base + 1, "R10 released", cap_n, base + 1);
        chk_char(base, 8'h11, 1'b0, 1'b0, 1'b0, "R10 held char");
        chk(ovr_cnt == 0, "R11 no overrun when released early", ovr_cnt, 0);
        fifo_full = 1'b1;
        send(8'h22, 8, 0, 1'b0, 1'b1);
        send(8'h66, 8, 0, 1'b0, 1'b1); drive(1'b1, 2);
        chk(ovr_cnt == 1, "R11 overrun pulse", ovr_cnt, 1);
        chk(cap_n == base + 1, "R11 nothing written while full", cap_n, base + 1);
        fifo_full = 1'b0; repeat (4) @(negedge clk);
        chk(cap_n == base + 2, "R11 survivor count", cap_n, base + 2);
        chk_char(base + 1, 8'h66, 1'b0, 1'b0, 1'b0, "R11 survivor char");

        // R12: watchdog
        wdog_en = 1'b1;
        send(8'h77, 8, 0, 1'b0, 1'b1);
        repeat (64 * BIT_CLK - 32 - 200) @(negedge clk);
        chk(wd_cnt == 0, "R12 not yet expired", wd_cnt, 0);
        repeat (400) @(negedge clk);
        chk(wd_cnt == 1, "R12 expired after 64 bits", wd_cnt, 1);
        fifo_read = 1'b1; @(negedge clk); fifo_read = 1'b0;
        repeat (64 * BIT_CLK - 200) @(negedge clk);
        chk(wd_cnt == 1, "R12 read restarts", wd_cnt, 1);
        repeat (400) @(negedge clk);
        chk(wd_cnt == 2, "R12 expired after read", wd_cnt, 2);
        repeat (70 * BIT_CLK) @(negedge clk);
        chk(wd_cnt == 2, "R12 single pulse", wd_cnt, 2);
        wdog_en = 1'b0;
        fifo_read = 1'b1; @(negedge clk); fifo_read = 1'b0;
        repeat (70 * BIT_CLK) @(negedge clk);
        chk(wd_cnt == 2, "R12 disabled silent", wd_cnt, 2);

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule